// File: doc/BRIEF.md
# Software-Managed TLB Search and Invalidate Unit

This block holds address translations that software loads one entry at a time. The translations live in two arrays. One is a small fully associative array. The other is a four-way set-associative array whose set comes from the low bits of the page number. Software writes an entry through a single load port. For the fully associative array it names the slot. For the set-associative array a round-robin victim pointer kept for each set picks the way.

A search command carries an effective address, together with an address-space bit and a process ID taken from a search-control register. Both arrays are probed in the same clock. The outcome is held in a set of result registers, and the valid bit of those registers is the success flag. On a hit the registers hold the fields of the entry that hit and tell which array, way and index it came from. On a miss they hold a ready-made template: the searched page, the process ID, the address space, and the victim way of the set. A following write can then create the missing entry.

An invalidate command forms its address as a base plus an index. It clears matching entries, or every entry, in one clock per array, and raises busy while it runs. Entries marked protected are never cleared.

Top module: `swtlb_unit`

## Requirements
- R1: A search whose `srch_base_nz` is 1 performs no lookup. One clock after it is sampled, `illegal` pulses high for one cycle, `srch_done` stays low, and every result register keeps its value.
- R2: The searched page number is `srch_ea[31:12]`. It is compared with the 20-bit page number stored in each entry.
- R3: An entry matches a search only if it is valid, its address-space bit equals `sctl_as`, its page number equals the searched page number, and its translation ID equals `sctl_pid`.
- R4: An entry whose translation ID is 0x00 matches a search for any process ID, provided R3's other conditions hold.
- R5: One search probes both arrays. A hit in the fully associative array wins over a hit in the set-associative array. Within an array, the lowest index or the lowest way wins.
- R6: On a hit the result registers take the entry's prot, AS, TID, page, RPN and attribute fields, with `res_valid`=1. The source is reported as follows. For the fully associative array: `res_in_fa`=1, `res_idx`=slot and `res_way`=0. For the set-associative array: `res_in_fa`=0, `res_idx`=set and `res_way`=way.
- R7: On a miss the result registers hold `res_valid`=0, `res_epn`=searched page, `res_tid`=`sctl_pid`, `res_as`=`sctl_as`, with prot, RPN and attributes at 0. They also hold `res_in_fa`=0, `res_idx`=set of the searched page, and `res_way`=that set's current victim pointer.
- R8: The search result is visible one clock after the command is sampled. In the same cycle `srch_done` pulses high for exactly one cycle.
- R9: The invalidate address is `inv_index` plus either 0 (when `inv_base_zero`=1) or `inv_base`. Without `inv_all`, every valid entry whose page number equals bits 31:12 of that sum is cleared. Address space and translation ID are ignored.
- R10: With `inv_all`=1 every entry is cleared. Under any invalidate, an entry whose prot bit is 1 stays valid.
- R11: An accepted invalidate raises `busy` for exactly two cycles, starting one clock after acceptance. Search, write and invalidate commands presented while `busy` is 1 are ignored.
- R12: A write with `wr_to_fa`=0 goes to set `wr_epn[2:0]` at the way named by that set's victim pointer. The pointer starts at 0 and advances by one, modulo 4, on each write to that set. A write with `wr_to_fa`=1 goes to slot `wr_fa_idx`.
- R13: When the unit is idle and several commands arrive in the same cycle, invalidate is taken first, then search, then write. The others are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| srch_req | input | 1 | Search command strobe |
| srch_base_nz | input | 1 | Search used a nonzero base selector (illegal form) |
| srch_ea | input | 32 | Search effective address |
| sctl_as | input | 1 | Search address-space bit |
| sctl_pid | input | 8 | Search process ID |
| inv_req | input | 1 | Invalidate command strobe |
| inv_base_zero | input | 1 | Base selector is zero; base value taken as 0 |
| inv_base | input | 32 | Invalidate base operand |
| inv_index | input | 32 | Invalidate index operand |
| inv_all | input | 1 | Invalidate every unprotected entry |
| wr_req | input | 1 | Entry write strobe |
| wr_to_fa | input | 1 | 1: write the fully associative array; 0: the set-associative array |
| wr_fa_idx | input | 2 | Slot in the fully associative array |
| wr_valid | input | 1 | Valid bit of the written entry |
| wr_prot | input | 1 | Protect bit of the written entry |
| wr_as | input | 1 | Address-space bit of the written entry |
| wr_tid | input | 8 | Translation ID of the written entry |
| wr_epn | input | 20 | Page number of the written entry |
| wr_rpn | input | 20 | Real page number of the written entry |
| wr_attr | input | 6 | Attribute bits of the written entry |
| busy | output | 1 | Invalidate in progress |
| srch_done | output | 1 | One-cycle pulse: search result updated |
| illegal | output | 1 | One-cycle pulse: illegal search form |
| res_valid | output | 1 | Result success flag |
| res_prot | output | 1 | Result protect bit |
| res_as | output | 1 | Result address-space bit |
| res_tid | output | 8 | Result translation ID |
| res_epn | output | 20 | Result page number |
| res_rpn | output | 20 | Result real page number |
| res_attr | output | 6 | Result attribute bits |
| res_in_fa | output | 1 | Hit came from the fully associative array |
| res_way | output | 2 | Hit way, or victim way on a miss |
| res_idx | output | 3 | Slot or set of the hit, or set on a miss |

## Verification
The hardest cases to reach are the ones that depend on history inside the arrays. One is a search that hits the same page in both arrays at once. Another is a miss template whose victim way reflects a pointer that has already wrapped. The stimulus writes five pages into one set so the pointer wraps and the oldest way is overwritten. It places one page in both arrays, and it fires commands while an invalidate is still running to show they are dropped. Protected entries in each array are then put through a targeted invalidate and a global invalidate, and later searches show they survived.

// File: rtl/swtlb_pkg.sv
package swtlb_pkg;

  localparam int EPN_W  = 20;
  localparam int PID_W  = 8;
  localparam int RPN_W  = 20;
  localparam int ATTR_W = 6;
  localparam int PG_LSB = 12;

  typedef struct packed {
    logic              valid;
    logic              prot;
    logic              as_id;
    logic [PID_W-1:0]  tid;
    logic [EPN_W-1:0]  epn;
    logic [RPN_W-1:0]  rpn;
    logic [ATTR_W-1:0] attr;
  } tlb_entry_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_INV_FA = 2'd1,
    ST_INV_SA = 2'd2
  } inv_state_e;

  // Page number held in an effective address.
  function automatic logic [EPN_W-1:0] ea_page(input logic [31:0] ea);
    return ea[31:PG_LSB];
  endfunction

  // Page number of the invalidate address (base may be forced to zero).
  function automatic logic [EPN_W-1:0] inv_page(input logic        base_zero,
                                                input logic [31:0] base,
                                                input logic [31:0] index);
    logic [31:0] sum;
    sum = (base_zero ? 32'd0 : base) + index;
    return sum[31:PG_LSB];
  endfunction

  // Search match rule; a zero translation ID is a wildcard.
  function automatic logic search_match(input tlb_entry_t       e,
                                        input logic [EPN_W-1:0] epn,
                                        input logic             as_id,
                                        input logic [PID_W-1:0] pid);
    return e.valid && (e.as_id == as_id) && (e.epn == epn) &&
           ((e.tid == '0) || (e.tid == pid));
  endfunction

  // Invalidate rule; protected entries are never cleared.
  function automatic logic inv_match(input tlb_entry_t       e,
                                     input logic             all,
                                     input logic [EPN_W-1:0] epn);
    return e.valid && !e.prot && (all || (e.epn == epn));
  endfunction

endpackage

// File: rtl/swtlb_fa_array.sv
module swtlb_fa_array
  import swtlb_pkg::*;
#(
  parameter  int N     = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EPN_W-1:0] key_epn,
  input  logic             key_as,
  input  logic [PID_W-1:0] key_pid,
  input  logic             inv_en,
  input  logic             inv_all,
  input  logic [EPN_W-1:0] inv_epn,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  tlb_entry_t       wr_entry,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx,
  output tlb_entry_t       hit_entry
);

  tlb_entry_t slot_all [N];

  for (genvar i = 0; i < N; i++) begin : g_slot
    tlb_entry_t slot_q;
    logic       clr_now;
    assign clr_now     = inv_en && inv_match(slot_q, inv_all, inv_epn);
    assign slot_all[i] = slot_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 slot_q       <= '0;
      else if (clr_now)                           slot_q.valid <= 1'b0;
      else if (wr_en && (wr_idx == IDX_W'(i)))    slot_q       <= wr_entry;
    end

    AST_FA_PROT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_en && slot_q.valid && slot_q.prot) |=> slot_q.valid); // R10
  end

  // Lowest slot wins.
  always_comb begin
    hit       = 1'b0;
    hit_idx   = '0;
    hit_entry = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (search_match(slot_all[i], key_epn, key_as, key_pid)) begin
        hit       = 1'b1;
        hit_idx   = IDX_W'(i);
        hit_entry = slot_all[i];
      end
    end
  end

endmodule

// File: rtl/swtlb_sa_array.sv
module swtlb_sa_array
  import swtlb_pkg::*;
#(
  parameter  int SETS  = 8,
  parameter  int WAYS  = 4,
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EPN_W-1:0] key_epn,
  input  logic             key_as,
  input  logic [PID_W-1:0] key_pid,
  input  logic             inv_en,
  input  logic             inv_all,
  input  logic [EPN_W-1:0] inv_epn,
  input  logic             wr_en,
  input  tlb_entry_t       wr_entry,
  output logic             hit,
  output logic [WAY_W-1:0] hit_way,
  output tlb_entry_t       hit_entry,
  output logic [SET_W-1:0] key_set,
  output logic [WAY_W-1:0] victim
);

  tlb_entry_t       ent_all  [SETS*WAYS];
  logic [WAY_W-1:0] vptr_all [SETS];
  logic [SET_W-1:0] wr_set;
  logic [SET_W-1:0] inv_set;

  assign wr_set  = wr_entry.epn[SET_W-1:0];
  assign inv_set = inv_epn[SET_W-1:0];
  assign key_set = key_epn[SET_W-1:0];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic [WAY_W-1:0] vptr_q;
    logic             set_wr;
    logic             set_inv;
    assign set_wr      = wr_en && (wr_set == SET_W'(s));
    assign set_inv     = inv_en && (inv_all || (inv_set == SET_W'(s)));
    assign vptr_all[s] = vptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      vptr_q <= '0;
      else if (set_wr) vptr_q <= vptr_q + 1'b1;
    end

    AST_VICTIM_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      set_wr |=> (vptr_q == WAY_W'($past(vptr_q) + 1'b1))); // R12

    for (genvar w = 0; w < WAYS; w++) begin : g_way
      tlb_entry_t ent_q;
      logic       clr_now;
      assign clr_now = set_inv && inv_match(ent_q, inv_all, inv_epn);
      assign ent_all[s*WAYS + w] = ent_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  ent_q       <= '0;
        else if (clr_now)                            ent_q.valid <= 1'b0;
        else if (set_wr && (vptr_q == WAY_W'(w)))    ent_q       <= wr_entry;
      end

      AST_SA_PROT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_en && ent_q.valid && ent_q.prot) |=> ent_q.valid); // R10
    end
  end

  assign victim = vptr_all[key_set];

  // Lowest way of the indexed set wins.
  always_comb begin
    hit       = 1'b0;
    hit_way   = '0;
    hit_entry = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (search_match(ent_all[int'(key_set)*WAYS + w], key_epn, key_as, key_pid)) begin
        hit       = 1'b1;
        hit_way   = WAY_W'(w);
        hit_entry = ent_all[int'(key_set)*WAYS + w];
      end
    end
  end

endmodule

// File: rtl/swtlb_unit.sv
module swtlb_unit
  import swtlb_pkg::*;
#(
  parameter  int FA_N   = 4,
  parameter  int SETS   = 8,
  parameter  int WAYS   = 4,
  localparam int FA_W   = (FA_N > 1) ? $clog2(FA_N) : 1,
  localparam int SET_W  = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int RIDX_W = (FA_W > SET_W) ? FA_W : SET_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              srch_req,
  input  logic              srch_base_nz,
  input  logic [31:0]       srch_ea,
  input  logic              sctl_as,
  input  logic [PID_W-1:0]  sctl_pid,
  input  logic              inv_req,
  input  logic              inv_base_zero,
  input  logic [31:0]       inv_base,
  input  logic [31:0]       inv_index,
  input  logic              inv_all,
  input  logic              wr_req,
  input  logic              wr_to_fa,
  input  logic [FA_W-1:0]   wr_fa_idx,
  input  logic              wr_valid,
  input  logic              wr_prot,
  input  logic              wr_as,
  input  logic [PID_W-1:0]  wr_tid,
  input  logic [EPN_W-1:0]  wr_epn,
  input  logic [RPN_W-1:0]  wr_rpn,
  input  logic [ATTR_W-1:0] wr_attr,
  output logic              busy,
  output logic              srch_done,
  output logic              illegal,
  output logic              res_valid,
  output logic              res_prot,
  output logic              res_as,
  output logic [PID_W-1:0]  res_tid,
  output logic [EPN_W-1:0]  res_epn,
  output logic [RPN_W-1:0]  res_rpn,
  output logic [ATTR_W-1:0] res_attr,
  output logic              res_in_fa,
  output logic [WAY_W-1:0]  res_way,
  output logic [RIDX_W-1:0] res_idx
);

  inv_state_e       state_q;
  logic             idle;
  logic             take_inv, take_srch, take_wr;
  logic             srch_legal, srch_bad;
  logic [EPN_W-1:0] key_epn;
  logic [EPN_W-1:0] inv_epn_q;
  logic             inv_all_q;
  tlb_entry_t       wr_entry;

  logic             fa_hit;
  logic [FA_W-1:0]  fa_idx;
  tlb_entry_t       fa_entry;
  logic             sa_hit;
  logic [WAY_W-1:0] sa_way;
  tlb_entry_t       sa_entry;
  logic [SET_W-1:0] sa_set;
  logic [WAY_W-1:0] sa_victim;

  tlb_entry_t        res_q;
  logic              in_fa_q;
  logic [WAY_W-1:0]  way_q;
  logic [RIDX_W-1:0] idx_q;
  logic              done_q, ill_q;

  // Command arbitration: invalidate, then search, then write.
  assign idle       = (state_q == ST_IDLE);
  assign take_inv   = idle && inv_req;
  assign take_srch  = idle && !inv_req && srch_req;
  assign take_wr    = idle && !inv_req && !srch_req && wr_req;
  assign srch_legal = take_srch && !srch_base_nz;
  assign srch_bad   = take_srch && srch_base_nz;
  assign key_epn    = ea_page(srch_ea);

  assign wr_entry = '{valid: wr_valid, prot: wr_prot, as_id: wr_as, tid: wr_tid,
                      epn: wr_epn, rpn: wr_rpn, attr: wr_attr};

  swtlb_fa_array #(.N(FA_N)) i_fa (
    .clk       (clk),
    .rst_n     (rst_n),
    .key_epn   (key_epn),
    .key_as    (sctl_as),
    .key_pid   (sctl_pid),
    .inv_en    (state_q == ST_INV_FA),
    .inv_all   (inv_all_q),
    .inv_epn   (inv_epn_q),
    .wr_en     (take_wr && wr_to_fa),
    .wr_idx    (wr_fa_idx),
    .wr_entry  (wr_entry),
    .hit       (fa_hit),
    .hit_idx   (fa_idx),
    .hit_entry (fa_entry)
  );

  swtlb_sa_array #(.SETS(SETS), .WAYS(WAYS)) i_sa (
    .clk       (clk),
    .rst_n     (rst_n),
    .key_epn   (key_epn),
    .key_as    (sctl_as),
    .key_pid   (sctl_pid),
    .inv_en    (state_q == ST_INV_SA),
    .inv_all   (inv_all_q),
    .inv_epn   (inv_epn_q),
    .wr_en     (take_wr && !wr_to_fa),
    .wr_entry  (wr_entry),
    .hit       (sa_hit),
    .hit_way   (sa_way),
    .hit_entry (sa_entry),
    .key_set   (sa_set),
    .victim    (sa_victim)
  );

  // Invalidate sequencer: one clock per array.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      inv_epn_q <= '0;
      inv_all_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (take_inv) begin
          state_q   <= ST_INV_FA;
          inv_epn_q <= inv_page(inv_base_zero, inv_base, inv_index);
          inv_all_q <= inv_all;
        end
        ST_INV_FA: state_q <= ST_INV_SA;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  // Result registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q   <= '0;
      in_fa_q <= 1'b0;
      way_q   <= '0;
      idx_q   <= '0;
      done_q  <= 1'b0;
      ill_q   <= 1'b0;
    end else begin
      done_q <= srch_legal;
      ill_q  <= srch_bad;
      if (srch_legal) begin
        if (fa_hit) begin
          res_q   <= fa_entry;
          in_fa_q <= 1'b1;
          way_q   <= '0;
          idx_q   <= RIDX_W'(fa_idx);
        end else if (sa_hit) begin
          res_q   <= sa_entry;
          in_fa_q <= 1'b0;
          way_q   <= sa_way;
          idx_q   <= RIDX_W'(sa_set);
        end else begin
          res_q   <= '{valid: 1'b0, prot: 1'b0, as_id: sctl_as, tid: sctl_pid,
                       epn: key_epn, rpn: '0, attr: '0};
          in_fa_q <= 1'b0;
          way_q   <= sa_victim;
          idx_q   <= RIDX_W'(sa_set);
        end
      end
    end
  end

  assign busy      = !idle;
  assign srch_done = done_q;
  assign illegal   = ill_q;
  assign res_valid = res_q.valid;
  assign res_prot  = res_q.prot;
  assign res_as    = res_q.as_id;
  assign res_tid   = res_q.tid;
  assign res_epn   = res_q.epn;
  assign res_rpn   = res_q.rpn;
  assign res_attr  = res_q.attr;
  assign res_in_fa = in_fa_q;
  assign res_way   = way_q;
  assign res_idx   = idx_q;

  AST_DONE_NOT_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    !(srch_done && illegal)); // R1
  AST_ILLEGAL_HOLDS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> ($stable(res_q) && $stable(idx_q) && $stable(way_q))); // R1
  AST_FA_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (srch_legal && fa_hit) |=> (res_in_fa && res_valid)); // R5
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    srch_legal |=> srch_done); // R8
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy); // R11
  AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |=> !busy); // R11
  AST_QUIET_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!srch_done && !illegal)); // R11

endmodule

// File: tb/test_swtlb_unit.sv
`timescale 1ns/1ps
module test_swtlb_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        srch_req = 0, srch_base_nz = 0, sctl_as = 0;
  logic [31:0] srch_ea = 0;
  logic [7:0]  sctl_pid = 0;
  logic        inv_req = 0, inv_base_zero = 0, inv_all = 0;
  logic [31:0] inv_base = 0, inv_index = 0;
  logic        wr_req = 0, wr_to_fa = 0, wr_valid = 0, wr_prot = 0, wr_as = 0;
  logic [1:0]  wr_fa_idx = 0;
  logic [7:0]  wr_tid = 0;
  logic [19:0] wr_epn = 0, wr_rpn = 0;
  logic [5:0]  wr_attr = 0;
  logic        busy, srch_done, illegal, res_valid, res_prot, res_as, res_in_fa;
  logic [7:0]  res_tid;
  logic [19:0] res_epn, res_rpn;
  logic [5:0]  res_attr;
  logic [1:0]  res_way;
  logic [2:0]  res_idx;

  always #2 clk = ~clk;

  swtlb_unit i_swtlb_unit (
    .clk(clk), .rst_n(rst_n),
    .srch_req(srch_req), .srch_base_nz(srch_base_nz), .srch_ea(srch_ea),
    .sctl_as(sctl_as), .sctl_pid(sctl_pid),
    .inv_req(inv_req), .inv_base_zero(inv_base_zero), .inv_base(inv_base),
    .inv_index(inv_index), .inv_all(inv_all),
    .wr_req(wr_req), .wr_to_fa(wr_to_fa), .wr_fa_idx(wr_fa_idx), .wr_valid(wr_valid),
    .wr_prot(wr_prot), .wr_as(wr_as), .wr_tid(wr_tid), .wr_epn(wr_epn),
    .wr_rpn(wr_rpn), .wr_attr(wr_attr),
    .busy(busy), .srch_done(srch_done), .illegal(illegal),
    .res_valid(res_valid), .res_prot(res_prot), .res_as(res_as), .res_tid(res_tid),
    .res_epn(res_epn), .res_rpn(res_rpn), .res_attr(res_attr),
    .res_in_fa(res_in_fa), .res_way(res_way), .res_idx(res_idx)
  );

  // ---------------- reference model ----------------
  typedef struct { bit v; bit p; bit as_; bit [7:0] tid; bit [19:0] epn; bit [19:0] rpn; bit [5:0] attr; } ment_t;
  ment_t fa_m [4];
  ment_t sa_m [8][4];
  int    vp_m [8];
  int    mstate = 0;
  bit [19:0] m_iepn;
  bit        m_iall;
  // expected outputs
  bit e_busy, e_done, e_ill, e_valid, e_prot, e_as, e_infa;
  bit [7:0] e_tid; bit [19:0] e_epn, e_rpn; bit [5:0] e_attr; bit [1:0] e_way; bit [2:0] e_idx;

  int n_checks = 0, n_fail = 0;
  bit chk_on = 0;
  string cur_req = "R6";

  function automatic bit m_hit(ment_t e, bit [19:0] pg, bit as_, bit [7:0] pid);
    return e.v && e.as_ == as_ && e.epn == pg && (e.tid == 8'h00 || e.tid == pid);
  endfunction

  function automatic void set_res(ment_t e);
    e_valid = e.v; e_prot = e.p; e_as = e.as_; e_tid = e.tid;
    e_epn = e.epn; e_rpn = e.rpn; e_attr = e.attr;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (fa_m[i]) fa_m[i] = '{default: 0};
      foreach (sa_m[s, w]) sa_m[s][w] = '{default: 0};
      foreach (vp_m[s]) vp_m[s] = 0;
      mstate = 0; e_busy = 0; e_done = 0; e_ill = 0; e_valid = 0; e_prot = 0; e_as = 0;
      e_infa = 0; e_tid = 0; e_epn = 0; e_rpn = 0; e_attr = 0; e_way = 0; e_idx = 0;
    end else begin
      e_done = 0; e_ill = 0;
      if (mstate == 1) begin
        foreach (fa_m[i]) if (fa_m[i].v && !fa_m[i].p && (m_iall || fa_m[i].epn == m_iepn)) fa_m[i].v = 0;
        mstate = 2;
      end else if (mstate == 2) begin
        foreach (sa_m[s, w]) if (sa_m[s][w].v && !sa_m[s][w].p && (m_iall || sa_m[s][w].epn == m_iepn)) sa_m[s][w].v = 0;
        mstate = 0;
      end else if (inv_req) begin
        bit [31:0] a;
        a = inv_base_zero ? 32'd0 : inv_base;
        a = a + inv_index;
        m_iepn = a[31:12]; m_iall = inv_all; mstate = 1;
      end else if (srch_req) begin
        if (srch_base_nz) e_ill = 1;
        else begin
          bit [19:0] pg; int set; bit found;
          pg = srch_ea[31:12]; set = pg % 8; found = 0; e_done = 1;
          for (int i = 0; i < 4 && !found; i++)
            if (m_hit(fa_m[i], pg, sctl_as, sctl_pid)) begin
              found = 1; set_res(fa_m[i]); e_infa = 1; e_way = 0; e_idx = 3'(i);
            end
          for (int w = 0; w < 4 && !found; w++)
            if (m_hit(sa_m[set][w], pg, sctl_as, sctl_pid)) begin
              found = 1; set_res(sa_m[set][w]); e_infa = 0; e_way = 2'(w); e_idx = 3'(set);
            end
          if (!found) begin
            e_valid = 0; e_prot = 0; e_as = sctl_as; e_tid = sctl_pid; e_epn = pg;
            e_rpn = 0; e_attr = 0; e_infa = 0; e_idx = 3'(set); e_way = 2'(vp_m[set]);
          end
        end
      end else if (wr_req) begin
        ment_t n;
        n = '{v: wr_valid, p: wr_prot, as_: wr_as, tid: wr_tid, epn: wr_epn, rpn: wr_rpn, attr: wr_attr};
        if (wr_to_fa) fa_m[wr_fa_idx] = n;
        else begin
          int set; set = wr_epn % 8;
          sa_m[set][vp_m[set]] = n; vp_m[set] = (vp_m[set] + 1) % 4;
        end
      end
      e_busy = (mstate != 0);
    end
  end

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (chk_on) begin
    check("R11", "busy", 64'(busy), 64'(e_busy));
    check("R8", "srch_done", 64'(srch_done), 64'(e_done));
    check("R1", "illegal", 64'(illegal), 64'(e_ill));
    check(cur_req, "result",
          64'({res_valid, res_prot, res_as, res_tid, res_epn, res_rpn, res_attr, res_in_fa, res_way, res_idx}),
          64'({e_valid, e_prot, e_as, e_tid, e_epn, e_rpn, e_attr, e_infa, e_way, e_idx}));
  end

  // ---------------- stimulus ----------------
  task automatic idle_all();
    srch_req = 0; srch_base_nz = 0; inv_req = 0; inv_all = 0; wr_req = 0;
  endtask

  task automatic do_wr(bit fa, bit [1:0] idx, bit v, bit p, bit as_, bit [7:0] tid,
                       bit [19:0] epn, bit [19:0] rpn, bit [5:0] attr);
    @(negedge clk);
    wr_req = 1; wr_to_fa = fa; wr_fa_idx = idx; wr_valid = v; wr_prot = p; wr_as = as_;
    wr_tid = tid; wr_epn = epn; wr_rpn = rpn; wr_attr = attr;
    @(negedge clk); idle_all();
  endtask

  task automatic do_srch(string req, bit [31:0] ea, bit as_, bit [7:0] pid, bit nz);
    @(negedge clk);
    cur_req = req;
    srch_req = 1; srch_ea = ea; sctl_as = as_; sctl_pid = pid; srch_base_nz = nz;
    @(negedge clk); idle_all();
  endtask

  task automatic do_inv(bit bz, bit [31:0] base, bit [31:0] idx, bit all);
    @(negedge clk);
    inv_req = 1; inv_base_zero = bz; inv_base = base; inv_index = idx; inv_all = all;
    @(negedge clk); idle_all();
    repeat (3) @(negedge clk);
  endtask

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8", "reset srch_done", 64'(srch_done), 64'd0);
    check("R11", "reset busy", 64'(busy), 64'd0);
    check("R6", "reset res_valid", 64'(res_valid), 64'd0);
    rst_n = 1;
    @(negedge clk); chk_on = 1;

    // Fully associative hit / misses (R2, R3, R6, R7)
    do_wr(1, 0, 1, 0, 0, 8'h05, 20'h12345, 20'hABCDE, 6'h15);
    do_srch("R2", 32'h1234_5678, 0, 8'h05, 0);
    do_srch("R6", 32'h1234_5FFF, 0, 8'h05, 0);
    do_srch("R3", 32'h1234_5000, 0, 8'h06, 0);
    do_srch("R3", 32'h1234_5000, 1, 8'h05, 0);
    do_srch("R7", 32'h1234_6000, 0, 8'h05, 0);
    // Wildcard translation ID, protected (R4)
    do_wr(1, 1, 1, 1, 0, 8'h00, 20'h0A0B0, 20'h11111, 6'h2A);
    do_srch("R4", 32'h0A0B_0000, 0, 8'h77, 0);
    do_srch("R4", 32'h0A0B_0123, 0, 8'h00, 0);
    // Set 3 fills and wraps (R12, R7)
    for (int k = 1; k <= 4; k++) do_wr(0, 0, 1, 0, 1, 8'h09, 20'(k*256 + 3), 20'(k), 6'h01);
    do_srch("R7", 32'h0050_3000, 1, 8'h09, 0);
    do_wr(0, 0, 1, 0, 1, 8'h09, 20'h00503, 20'h00005, 6'h02);
    do_srch("R12", 32'h0010_3000, 1, 8'h09, 0);
    do_srch("R12", 32'h0050_3000, 1, 8'h09, 0);
    do_srch("R12", 32'h0030_3000, 1, 8'h09, 0);
    do_srch("R7", 32'h0060_3000, 1, 8'h09, 0);
    // Same page in both arrays (R5); set-associative-only hit
    do_wr(0, 0, 1, 0, 0, 8'h05, 20'h12345, 20'h0BEEF, 6'h3F);
    do_srch("R5", 32'h1234_5000, 0, 8'h05, 0);
    do_srch("R5", 32'h0020_3000, 1, 8'h09, 0);
    // Illegal form (R1)
    do_srch("R1", 32'h0A0B_0000, 0, 8'h01, 1);
    do_srch("R1", 32'h1234_5000, 0, 8'h05, 1);
    // Targeted invalidates (R9, R10)
    do_inv(1, 32'hFFFF_FFFF, 32'h1234_5000, 0);
    do_srch("R9", 32'h1234_5000, 0, 8'h05, 0);
    do_inv(0, 32'h0030_0000, 32'h0000_3ABC, 0);
    do_srch("R9", 32'h0030_3000, 1, 8'h09, 0);
    do_srch("R9", 32'h0050_3000, 1, 8'h09, 0);
    do_inv(1, 32'h0, 32'h0A0B_0000, 0);
    do_srch("R10", 32'h0A0B_0000, 0, 8'h33, 0);
    // Priority and commands during busy (R13, R11)
    @(negedge clk);
    inv_req = 1; inv_base_zero = 1; inv_index = 32'h7777_7000; srch_req = 1;
    srch_ea = 32'h0A0B_0000; sctl_as = 0; sctl_pid = 8'h44; cur_req = "R13";
    @(negedge clk); idle_all();
    srch_req = 1; srch_ea = 32'h0A0B_0000; cur_req = "R11";
    @(negedge clk); idle_all();
    wr_req = 1; wr_to_fa = 1; wr_fa_idx = 3; wr_valid = 1; wr_prot = 0; wr_as = 0;
    wr_tid = 8'h00; wr_epn = 20'h55555;
    @(negedge clk); idle_all();
    repeat (2) @(negedge clk);
    do_srch("R11", 32'h5555_5000, 0, 8'h00, 0);
    // Global invalidate, protected entry in each array (R10)
    do_wr(0, 0, 1, 1, 0, 8'h00, 20'h00777, 20'h00077, 6'h07);
    do_wr(1, 2, 1, 0, 0, 8'h00, 20'h00888, 20'h00088, 6'h08);
    do_inv(0, 32'h0, 32'h0, 1);
    do_srch("R10", 32'h0077_7000, 0, 8'h12, 0);
    do_srch("R10", 32'h0088_8000, 0, 8'h12, 0);
    do_srch("R10", 32'h0040_3000, 1, 8'h09, 0);
    do_srch("R10", 32'h0A0B_0000, 0, 8'h12, 0);
    repeat (2) @(negedge clk);
    chk_on = 0;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule